// File: doc/BRIEF.md
# Sequential-Write Convolutional Interleaver Address Generator

This block generates the write and read addresses for a convolutional interleaver that keeps all of its symbols in one linear circular buffer, typically an external SDRAM. Symbols are written strictly in arrival order, so the write side walks through each memory row completely before it moves on to the next one. The interleaving is done entirely on the read side. For every symbol, the read address points back into the buffer by a distance that depends on the symbol's branch.

Each accepted symbol gets the next branch in a fixed rotation. Branch `b` delays its data by `b * UNIT * N_BR` symbol periods, so branch 0 passes data straight through. The block also reports two things to the memory controller. It flags the writes that start a new memory row, so the controller can keep a row open across a burst of writes. It also flags reads that fall before the delay line has filled, so they can be treated as fill data. The read stream stays scattered across rows, which is inherent to interleaving.

Top module: `cil_addr_gen`

## Requirements
- R1: `br_idx` gives the branch of the symbol just accepted. It starts at 0 after reset, goes up by one for each accepted symbol, and returns from `N_BR-1` to 0.
- R2: `wr_addr` equals the accepted symbol's sequence number `t` (counted from 0 after reset) modulo `DEPTH`. It therefore steps by one and wraps from `DEPTH-1` to 0.
- R3: `rd_addr` equals `(t - br*UNIT*N_BR)` reduced into the range 0 to `DEPTH-1`. This holds even when the subtraction drops below zero, and the result is never `DEPTH` or more.
- R4: `wr_en` and `rd_en` are both high in exactly the cycle after a cycle with `sym_valid` high. All address, branch and flag outputs for that symbol appear in that same cycle.
- R5: `rd_live` is low while `t < br*UNIT*N_BR` and high otherwise. Every symbol on branch 0 is therefore live, and the read strobe is issued either way.
- R6: `wr_row_start` is high together with `wr_en` exactly when the low `log2(ROW)` bits of `wr_addr` are zero. This includes address 0 after a wrap.
- R7: A synchronous active-high `rst` sets every output to 0 and clears the branch, write pointer and fill state. The next symbol after reset is treated as `t = 0`.
- R8: In a cycle after `sym_valid` was low, both strobes are low, and `wr_addr`, `rd_addr` and `br_idx` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_valid | input | 1 | A symbol is accepted this cycle |
| wr_en | output | 1 | Write strobe for the symbol accepted last cycle |
| wr_addr | output | $clog2(DEPTH) | Sequential write address |
| wr_row_start | output | 1 | This write opens a new memory row |
| rd_en | output | 1 | Read strobe, paired with `wr_en` |
| rd_addr | output | $clog2(DEPTH) | Delayed read address for the same branch |
| rd_live | output | 1 | Read returns real data, not fill |
| br_idx | output | $clog2(N_BR) | Branch of the symbol just accepted |

## Verification
Two events can land on the same symbol: the write pointer wrapping to address 0 (which also opens a row), and the read subtraction crossing below zero. The bench builds a small instance with a buffer depth that is not a power of two and is not a multiple of the row size. It then streams well over 100 symbols through it, so wraps fall on every branch in turn, including symbols where the write is at 0 while the read folds back to the top of the buffer. Every symbol is compared against a reference computed from `t` alone, with the row flag judged directly from the write address.

// File: rtl/cil_pkg.sv
package cil_pkg;
   // Largest branch delay in symbols: (branches-1) * unit * branches.
   function automatic int cil_max_delay(input int n_br, input int unit);
      return (n_br - 1) * unit * n_br;
   endfunction
endpackage

// File: rtl/cil_commutator.sv
module cil_commutator #(
   parameter int N_BR     = 40,
   parameter int UNIT     = 200,
   parameter int AW       = 19,
   parameter bit OFF_MULT = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     adv,
   output logic [$clog2(N_BR)-1:0]  br,
   output logic [AW-1:0]            off
);
   localparam int BW    = $clog2(N_BR);
   localparam int STEP  = UNIT * N_BR;
   localparam logic [BW-1:0] BR_LAST = BW'(N_BR - 1);

   logic br_wrap;
   assign br_wrap = (br == BR_LAST);

   always_ff @(posedge clk) begin
      if (rst)      br <= '0;
      else if (adv) br <= br_wrap ? '0 : br + 1'b1;
   end

   generate
      if (OFF_MULT) begin : g_off_mult
         // Offset derived from the branch index with a constant multiply.
         assign off = AW'(int'(br) * STEP);
      end else begin : g_off_acc
         // Offset kept in step with the branch by adding one stride per symbol.
         logic [AW-1:0] off_q;
         always_ff @(posedge clk) begin
            if (rst)      off_q <= '0;
            else if (adv) off_q <= br_wrap ? '0 : off_q + AW'(STEP);
         end
         assign off = off_q;
      end
   endgenerate

   a_r1_br_range: assert property (@(posedge clk) disable iff (rst)
      int'(br) < N_BR);
   a_r8_br_hold: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(br));
   a_r1_br_return: assert property (@(posedge clk) disable iff (rst)
      (adv && br_wrap) |=> (br == '0));
endmodule

// File: rtl/cil_wrptr.sv
module cil_wrptr #(
   parameter int DEPTH = 312320,
   parameter int MAXD  = 312000,
   parameter int AW    = 19
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          adv,
   output logic [AW-1:0] wp,
   output logic [AW-1:0] fill
);
   localparam logic [AW-1:0] WP_LAST  = AW'(DEPTH - 1);
   localparam logic [AW-1:0] FILL_TOP = AW'(MAXD);

   always_ff @(posedge clk) begin
      if (rst)      wp <= '0;
      else if (adv) wp <= (wp == WP_LAST) ? '0 : wp + 1'b1;
   end

   // Symbol count, saturating once every branch has filled.
   always_ff @(posedge clk) begin
      if (rst)                          fill <= '0;
      else if (adv && fill != FILL_TOP) fill <= fill + 1'b1;
   end

   a_r2_wp_range: assert property (@(posedge clk) disable iff (rst)
      int'(wp) < DEPTH);
   a_r2_wp_wrap: assert property (@(posedge clk) disable iff (rst)
      (adv && wp == WP_LAST) |=> (wp == '0));
   a_r5_fill_bound: assert property (@(posedge clk) disable iff (rst)
      fill <= FILL_TOP);
endmodule

// File: rtl/cil_rdaddr.sv
module cil_rdaddr #(
   parameter int DEPTH = 312320,
   parameter int AW    = 19
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          adv,
   input  logic [AW-1:0] wp,
   input  logic [AW-1:0] off,
   input  logic [AW-1:0] fill,
   output logic          rd_en,
   output logic [AW-1:0] rd_addr,
   output logic          rd_live
);
   localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

   logic [AW:0]   folded;
   logic [AW-1:0] rd_next;

   // Backward distance with fold-over into the top of the buffer.
   always_comb begin
      folded  = {1'b0, wp} + DEPTH_V - {1'b0, off};
      rd_next = (wp >= off) ? (wp - off) : folded[AW-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_en   <= 1'b0;
         rd_addr <= '0;
         rd_live <= 1'b0;
      end else begin
         rd_en <= adv;
         if (adv) begin
            rd_addr <= rd_next;
            rd_live <= (fill >= off);
         end
      end
   end

   a_r3_rd_range: assert property (@(posedge clk) disable iff (rst)
      rd_en |-> (int'(rd_addr) < DEPTH));
   a_r8_rd_hold: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(rd_addr));
endmodule

// File: rtl/cil_addr_gen.sv
module cil_addr_gen
   import cil_pkg::*;
#(
   parameter int N_BR     = 40,
   parameter int UNIT     = 200,
   parameter int DEPTH    = 312320,
   parameter int ROW      = 256,
   parameter bit OFF_MULT = 1'b0
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         sym_valid,
   output logic                         wr_en,
   output logic [$clog2(DEPTH)-1:0]     wr_addr,
   output logic                         wr_row_start,
   output logic                         rd_en,
   output logic [$clog2(DEPTH)-1:0]     rd_addr,
   output logic                         rd_live,
   output logic [$clog2(N_BR)-1:0]      br_idx
);
   localparam int AW   = $clog2(DEPTH);
   localparam int BW   = $clog2(N_BR);
   localparam int MAXD = cil_max_delay(N_BR, UNIT);
   localparam logic [AW-1:0] ROW_MASK = AW'(ROW - 1);

   generate
      if (N_BR < 2) begin : g_bad_nbr
         $error("cil_addr_gen: N_BR must be at least 2");
      end
      if (DEPTH <= MAXD) begin : g_bad_depth
         $error("cil_addr_gen: DEPTH must exceed the largest branch delay");
      end
      if (ROW < 2 || (ROW & (ROW - 1)) != 0) begin : g_bad_row
         $error("cil_addr_gen: ROW must be a power of two, at least 2");
      end
   endgenerate

   logic [BW-1:0] br_cur;
   logic [AW-1:0] off_cur;
   logic [AW-1:0] wp_cur;
   logic [AW-1:0] fill_cur;

   cil_commutator #(
      .N_BR     (N_BR),
      .UNIT     (UNIT),
      .AW       (AW),
      .OFF_MULT (OFF_MULT)
   ) u_comm (
      .clk (clk),
      .rst (rst),
      .adv (sym_valid),
      .br  (br_cur),
      .off (off_cur)
   );

   cil_wrptr #(
      .DEPTH (DEPTH),
      .MAXD  (MAXD),
      .AW    (AW)
   ) u_wptr (
      .clk  (clk),
      .rst  (rst),
      .adv  (sym_valid),
      .wp   (wp_cur),
      .fill (fill_cur)
   );

   cil_rdaddr #(
      .DEPTH (DEPTH),
      .AW    (AW)
   ) u_rd (
      .clk     (clk),
      .rst     (rst),
      .adv     (sym_valid),
      .wp      (wp_cur),
      .off     (off_cur),
      .fill    (fill_cur),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .rd_live (rd_live)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_en        <= 1'b0;
         wr_addr      <= '0;
         wr_row_start <= 1'b0;
         br_idx       <= '0;
      end else begin
         wr_en        <= sym_valid;
         wr_row_start <= sym_valid && ((wp_cur & ROW_MASK) == '0);
         if (sym_valid) begin
            wr_addr <= wp_cur;
            br_idx  <= br_cur;
         end
      end
   end

   a_r4_strobe_pair: assert property (@(posedge clk) disable iff (rst)
      wr_en == rd_en);
   a_r4_read_follows: assert property (@(posedge clk) disable iff (rst)
      sym_valid |=> rd_en);
   a_r5_branch0_live: assert property (@(posedge clk) disable iff (rst)
      (rd_en && br_idx == '0) |-> rd_live);
   a_r6_row_needs_write: assert property (@(posedge clk) disable iff (rst)
      wr_row_start |-> (wr_en && (wr_addr & ROW_MASK) == '0));
   a_r3_branch0_same: assert property (@(posedge clk) disable iff (rst)
      (rd_en && br_idx == '0) |-> (rd_addr == wr_addr));
endmodule

// File: tb/cil_addr_gen_tb.sv
module cil_addr_gen_tb;
   localparam int N_BR  = 4;
   localparam int UNIT  = 2;
   localparam int DEPTH = 29;
   localparam int ROW   = 8;
   localparam int STEP  = UNIT * N_BR;
   localparam int AW    = $clog2(DEPTH);
   localparam int BW    = $clog2(N_BR);

   // Packed entry: {gap[1:0], br[1:0], wr[4:0], rd[4:0], live}
   localparam logic [14:0] VEC [12] = '{
      {2'd0, 2'd0, 5'd0,  5'd0,  1'b1},
      {2'd0, 2'd1, 5'd1,  5'd22, 1'b0},
      {2'd0, 2'd2, 5'd2,  5'd15, 1'b0},
      {2'd1, 2'd3, 5'd3,  5'd8,  1'b0},
      {2'd0, 2'd0, 5'd4,  5'd4,  1'b1},
      {2'd0, 2'd1, 5'd5,  5'd26, 1'b0},
      {2'd2, 2'd2, 5'd6,  5'd19, 1'b0},
      {2'd0, 2'd3, 5'd7,  5'd12, 1'b0},
      {2'd0, 2'd0, 5'd8,  5'd8,  1'b1},
      {2'd1, 2'd1, 5'd9,  5'd1,  1'b1},
      {2'd0, 2'd2, 5'd10, 5'd23, 1'b0},
      {2'd0, 2'd3, 5'd11, 5'd16, 1'b0}
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          sym_valid = 1'b0;
   logic          wr_en, wr_row_start, rd_en, rd_live;
   logic [AW-1:0] wr_addr, rd_addr;
   logic [BW-1:0] br_idx;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;
   int  t_model = 0;

   always #2.5 clk = ~clk;

   cil_addr_gen #(
      .N_BR (N_BR), .UNIT (UNIT), .DEPTH (DEPTH), .ROW (ROW), .OFF_MULT (1'b0)
   ) u_dut (
      .clk (clk), .rst (rst), .sym_valid (sym_valid),
      .wr_en (wr_en), .wr_addr (wr_addr), .wr_row_start (wr_row_start),
      .rd_en (rd_en), .rd_addr (rd_addr), .rd_live (rd_live), .br_idx (br_idx)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Idle cycles: strobes low, addresses and branch held (R8).
   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         int pw = int'(wr_addr);
         int pr = int'(rd_addr);
         int pb = int'(br_idx);
         sym_valid = 1'b0;
         @(posedge clk); @(negedge clk);
         chk("R8 wr_en idle", int'(wr_en), 0);
         chk("R8 rd_en idle", int'(rd_en), 0);
         chk("R8 wr_addr hold", int'(wr_addr), pw);
         chk("R8 rd_addr hold", int'(rd_addr), pr);
         chk("R8 br_idx hold", int'(br_idx), pb);
      end
   endtask

   // One symbol, compared with values computed from its sequence number.
   task automatic send_model();
      int br = t_model % N_BR;
      int wr = t_model % DEPTH;
      int rd = (t_model - br * STEP) % DEPTH;
      if (rd < 0) rd += DEPTH;
      sym_valid = 1'b1;
      @(posedge clk); @(negedge clk);
      sym_valid = 1'b0;
      chk("R4 wr_en", int'(wr_en), 1);
      chk("R4 rd_en", int'(rd_en), 1);
      chk("R1 br_idx", int'(br_idx), br);
      chk("R2 wr_addr", int'(wr_addr), wr);
      chk("R3 rd_addr", int'(rd_addr), rd);
      chk("R5 rd_live", int'(rd_live), (t_model >= br * STEP) ? 1 : 0);
      chk("R6 wr_row_start", int'(wr_row_start), (wr % ROW == 0) ? 1 : 0);
      t_model++;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      repeat (3) @(negedge clk);
      // R7 reset state
      chk("R7 wr_en reset", int'(wr_en), 0);
      chk("R7 rd_en reset", int'(rd_en), 0);
      chk("R7 wr_addr reset", int'(wr_addr), 0);
      chk("R7 rd_addr reset", int'(rd_addr), 0);
      chk("R7 br_idx reset", int'(br_idx), 0);
      chk("R7 rd_live reset", int'(rd_live), 0);
      rst = 1'b0;
      @(negedge clk);

      // Table walk: first symbols, with idle gaps between some of them.
      for (int v = 0; v < 12; v++) begin
         idle(int'(VEC[v][14:13]));
         sym_valid = 1'b1;
         @(posedge clk); @(negedge clk);
         sym_valid = 1'b0;
         chk("R4 table strobe", int'(wr_en & rd_en), 1);
         chk("R1 table br", int'(br_idx), int'(VEC[v][12:11]));
         chk("R2 table wr", int'(wr_addr), int'(VEC[v][10:6]));
         chk("R3 table rd", int'(rd_addr), int'(VEC[v][5:1]));
         chk("R5 table live", int'(rd_live), int'(VEC[v][0]));
         chk("R6 table row", int'(wr_row_start), (int'(VEC[v][10:6]) % ROW == 0) ? 1 : 0);
         t_model++;
      end

      // Long run: several buffer wraps, warm-up saturation, mixed gaps.
      for (int k = 0; k < 130; k++) begin
         if (k % 7 == 3) idle(1);
         send_model();
      end

      // R7 mid-stream reset, then restart from t = 0
      rst = 1'b1;
      @(posedge clk); @(negedge clk);
      @(posedge clk); @(negedge clk);
      chk("R7 wr_en mid reset", int'(wr_en), 0);
      chk("R7 wr_addr mid reset", int'(wr_addr), 0);
      chk("R7 br_idx mid reset", int'(br_idx), 0);
      chk("R7 rd_live mid reset", int'(rd_live), 0);
      rst = 1'b0;
      t_model = 0;
      send_model();
      send_model();
      chk("R7 fill restarted", int'(rd_live), 0);
      for (int k = 0; k < 40; k++) send_model();

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule